// File: doc/BRIEF.md
# LCD Panel Timing Generator

This block makes the control pulses for the row drivers and column drivers of a VGA-class liquid crystal panel. It also makes horizontal and vertical sync and a data-enable window. A pixel counter and a line counter are clocked by the 27 MHz dot clock. The pixel counter wraps at a programmable line length, and each wrap steps the line counter, which wraps at a programmable frame height. A two-bit frame counter steps at each frame wrap.

Eight pulse channels share one comparator form. Each channel has its own start, width and invert setting. A channel is active while its counter lies in the range from start up to, but not including, start plus width. The result is XORed with the invert bit and registered. Horizontal channels compare the pixel count and vertical channels compare the line count. The channel map is:

| Index | Channel | Counter |
|---|---|---|
| 0 | gate start | line |
| 1 | gate output enable | pixel |
| 2 | gate clock | pixel |
| 3 | source strobe | pixel |
| 4 | source start | pixel |
| 5 | gate reset | line |
| 6 | hsync | pixel |
| 7 | vsync | line |

The block also produces:
- a line-polarity signal with line and frame inversion cadences;
- pixel-reversal signals for single-phase and two-phase panels;
- output enables for the pins that can be moved to an alternate pin.

Every setting is copied into shadow registers in two cases: during reset, and on the clock that ends a frame. A setting written partway through a frame therefore waits until the next frame.

Top module: `lcd_tcon_gen`

## Requirements
- R1: While reset is sampled high, every pulse channel output equals its invert input, `de` equals `de_inv`, `line_pol` is 0, `pix_rev` equals `rev_inv` and `pix_rev_e` equals its inverse. After reset is released, counting starts from pixel 0, line 0, frame 0.
- R2: The pixel counter runs from 0 to `h_total`-1 and then wraps. Each wrap steps the line counter, which runs from 0 to `v_total`-1 and then wraps. The hsync channel (index 6) shows this cadence.
- R3: Each output of a pixel-counter channel (indices 1, 2, 3, 4, 6) is registered. One clock after the pixel counter holds value c, it shows (start <= c < start+width) XOR invert.
- R4: The line-counter channels (indices 0, 5, 7) follow the rule in R3, with the current line count in place of c.
- R5: One clock after position (h, v), `de` equals (h inside the horizontal window AND v inside the vertical window) XOR `de_inv`. Each window runs from its start up to, but not including, start plus length.
- R6: `line_pol` changes only on the clock after the pixel count equals `pol_pos`. It then loads (line bit) XOR (frame bit). The line bit is bit 0 of the line count, or bit 1 when `pol_two_line`=1. The frame bit is bit 0 of the frame count, or bit 1 when `pol_two_frame`=1.
- R7: When `two_phase`=0, `pix_rev` equals `rev_inv` XOR bit 0 of the previous pixel count. When `two_phase`=1, `pix_rev` holds `rev_inv` as the odd-pixel copy. `pix_rev_e` is always the inverse of `rev_inv`, and its enable equals `two_phase`.
- R8: `gate_start_alt` and `src_start_alt` carry the same values as their primary channels. Each select bit drives the alternate copy's enable to 1 and the primary copy's enable to 0, and a clear select bit does the reverse.
- R9: The block copies every setting into shadow registers during reset and on the last clock of a frame, and uses only the shadow copies. A setting changed partway through a frame has no effect on any output until the next frame.
- R10: A channel whose width is 0 never asserts. Its output stays at its invert level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Dot clock |
| rst | input | 1 | Synchronous reset, active high |
| h_total | input | CW | Pixels per line |
| v_total | input | CW | Lines per frame |
| p_start | input | NP x CW | Start count of each pulse channel |
| p_width | input | NP x CW | Width of each pulse channel |
| p_inv | input | NP | Invert bit of each pulse channel |
| de_h_start | input | CW | Horizontal window start |
| de_h_len | input | CW | Horizontal window length |
| de_v_start | input | CW | Vertical window start |
| de_v_len | input | CW | Vertical window length |
| de_inv | input | 1 | Data-enable invert |
| pol_pos | input | CW | Pixel at which the line polarity updates |
| pol_two_line | input | 1 | Line polarity flips every two lines |
| pol_two_frame | input | 1 | Line polarity flips every two frames |
| rev_inv | input | 1 | Pixel-reversal invert |
| two_phase | input | 1 | Two-phase panel mode |
| sel_gate_alt | input | 1 | Move gate start to its alternate pin |
| sel_src_alt | input | 1 | Move source start to its alternate pin |
| gate_start | output | 1 | Gate start pulse |
| gate_start_oe | output | 1 | Output enable of the gate start pin |
| gate_start_alt | output | 1 | Alternate gate start pulse |
| gate_start_alt_oe | output | 1 | Output enable of the alternate gate start pin |
| gate_oe | output | 1 | Gate output enable pulse |
| gate_clk | output | 1 | Gate clock pulse |
| src_strobe | output | 1 | Source strobe pulse |
| src_start | output | 1 | Source start pulse |
| src_start_oe | output | 1 | Output enable of the source start pin |
| src_start_alt | output | 1 | Alternate source start pulse |
| src_start_alt_oe | output | 1 | Output enable of the alternate source start pin |
| gate_reset | output | 1 | Gate reset pulse |
| hsync | output | 1 | Horizontal sync |
| vsync | output | 1 | Vertical sync |
| de | output | 1 | Data enable |
| line_pol | output | 1 | Source voltage polarity |
| pix_rev | output | 1 | Pixel reversal; odd-pixel copy in two-phase mode |
| pix_rev_e | output | 1 | Even-pixel reversal |
| pix_rev_e_oe | output | 1 | Output enable of the even-pixel reversal pin |

## Verification
The assertions take four things for granted:
- `h_total` and `v_total` are at least 4, so the counters and the polarity bits cycle.
- `pol_pos` lies below the line length, so the polarity update is reached on every line.
- The totals are never shrunk below the current count outside a frame boundary. The shadow copy makes this hold by itself.
- The pin selections are changed only with reset low or at frame boundaries, as seen through the shadows.

The stimulus keeps to these limits. It uses small frames of 12 to 16 pixels by 6 or 7 lines. Every setting comes from a formula indexed by a configuration number, and those formulas keep the polarity position inside the line. Settings are rewritten at arbitrary points partway through a frame, and reset is asserted once in the middle of a run.

// File: rtl/lcd_tcon_gen.sv
module lcd_tcon_gen #(
  parameter int CW = 10
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic [CW-1:0]          h_total,
  input  logic [CW-1:0]          v_total,
  input  logic [7:0][CW-1:0]     p_start,
  input  logic [7:0][CW-1:0]     p_width,
  input  logic [7:0]             p_inv,
  input  logic [CW-1:0]          de_h_start,
  input  logic [CW-1:0]          de_h_len,
  input  logic [CW-1:0]          de_v_start,
  input  logic [CW-1:0]          de_v_len,
  input  logic                   de_inv,
  input  logic [CW-1:0]          pol_pos,
  input  logic                   pol_two_line,
  input  logic                   pol_two_frame,
  input  logic                   rev_inv,
  input  logic                   two_phase,
  input  logic                   sel_gate_alt,
  input  logic                   sel_src_alt,
  output logic                   gate_start,
  output logic                   gate_start_oe,
  output logic                   gate_start_alt,
  output logic                   gate_start_alt_oe,
  output logic                   gate_oe,
  output logic                   gate_clk,
  output logic                   src_strobe,
  output logic                   src_start,
  output logic                   src_start_oe,
  output logic                   src_start_alt,
  output logic                   src_start_alt_oe,
  output logic                   gate_reset,
  output logic                   hsync,
  output logic                   vsync,
  output logic                   de,
  output logic                   line_pol,
  output logic                   pix_rev,
  output logic                   pix_rev_e,
  output logic                   pix_rev_e_oe
);
  localparam int NP = 8;
  localparam logic [NP-1:0] LINE_DOM = 8'b1010_0001;

  logic [CW-1:0] hcnt, vcnt;
  logic [1:0]    fcnt;

  logic [CW-1:0]         ht_s, vt_s, dhs_s, dhl_s, dvs_s, dvl_s, ppos_s;
  logic [NP-1:0][CW-1:0] ps_s, pw_s;
  logic [NP-1:0]         pi_s;
  logic                  dinv_s, p2l_s, p2f_s, rinv_s, two_s, sga_s, ssa_s;

  logic [NP-1:0] pulse_q;

  wire h_end     = (hcnt == ht_s - CW'(1));
  wire frame_end = h_end && (vcnt == vt_s - CW'(1));

  function automatic logic in_win(input logic [CW-1:0] c, input logic [CW-1:0] s,
                                  input logic [CW-1:0] w);
    return ({1'b0, c} >= {1'b0, s}) && ({1'b0, c} < ({1'b0, s} + {1'b0, w}));
  endfunction

  // Settings are sampled during reset and on the last clock of a frame (R9)
  always_ff @(posedge clk) begin
    if (rst || frame_end) begin
      ht_s   <= h_total;    vt_s   <= v_total;
      ps_s   <= p_start;    pw_s   <= p_width;    pi_s <= p_inv;
      dhs_s  <= de_h_start; dhl_s  <= de_h_len;
      dvs_s  <= de_v_start; dvl_s  <= de_v_len;   dinv_s <= de_inv;
      ppos_s <= pol_pos;    p2l_s  <= pol_two_line; p2f_s <= pol_two_frame;
      rinv_s <= rev_inv;    two_s  <= two_phase;
      sga_s  <= sel_gate_alt; ssa_s <= sel_src_alt;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hcnt <= '0;
      vcnt <= '0;
      fcnt <= '0;
    end else begin
      if (h_end) begin
        hcnt <= '0;
        vcnt <= frame_end ? '0 : vcnt + CW'(1);
      end else begin
        hcnt <= hcnt + CW'(1);
      end
      if (frame_end) fcnt <= fcnt + 2'd1;
    end
  end

  for (genvar i = 0; i < NP; i++) begin : g_pulse
    wire [CW-1:0] cnt = LINE_DOM[i] ? vcnt : hcnt;
    always_ff @(posedge clk) begin
      if (rst) pulse_q[i] <= p_inv[i];
      else     pulse_q[i] <= in_win(cnt, ps_s[i], pw_s[i]) ^ pi_s[i];
    end
  end

  assign gate_start = pulse_q[0];
  assign gate_oe    = pulse_q[1];
  assign gate_clk   = pulse_q[2];
  assign src_strobe = pulse_q[3];
  assign src_start  = pulse_q[4];
  assign gate_reset = pulse_q[5];
  assign hsync      = pulse_q[6];
  assign vsync      = pulse_q[7];

  assign gate_start_alt    = pulse_q[0];
  assign src_start_alt     = pulse_q[4];
  assign gate_start_oe     = ~sga_s;
  assign gate_start_alt_oe = sga_s;
  assign src_start_oe      = ~ssa_s;
  assign src_start_alt_oe  = ssa_s;
  assign pix_rev_e_oe      = two_s;

  always_ff @(posedge clk) begin
    if (rst) de <= de_inv;
    else     de <= (in_win(hcnt, dhs_s, dhl_s) && in_win(vcnt, dvs_s, dvl_s)) ^ dinv_s;
  end

  always_ff @(posedge clk) begin
    if (rst)
      line_pol <= 1'b0;
    else if (hcnt == ppos_s)
      line_pol <= (p2l_s ? vcnt[1] : vcnt[0]) ^ (p2f_s ? fcnt[1] : fcnt[0]);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pix_rev   <= rev_inv;
      pix_rev_e <= ~rev_inv;
    end else begin
      pix_rev   <= rinv_s ^ (~two_s & hcnt[0]);
      pix_rev_e <= ~rinv_s;
    end
  end

  AST_LINE_WRAP: assert property (@(posedge clk) disable iff (rst)
    h_end |=> (hcnt == '0)); // R2

  AST_ZERO_WIDTH: assert property (@(posedge clk) disable iff (rst)
    (pw_s[2] == '0) |=> (gate_clk == $past(pi_s[2]))); // R10

  AST_DE_OUTSIDE: assert property (@(posedge clk) disable iff (rst)
    !in_win(vcnt, dvs_s, dvl_s) |=> (de == $past(dinv_s))); // R5

  AST_POL_HOLD: assert property (@(posedge clk) disable iff (rst)
    (hcnt != ppos_s) |=> $stable(line_pol)); // R6

  AST_SEL_FRAME: assert property (@(posedge clk) disable iff (rst)
    (!$stable(gate_start_alt_oe) && !$past(rst)) |-> $past(frame_end)); // R9

  AST_ALT_COPY: assert property (@(posedge clk) disable iff (rst)
    (gate_start_alt == gate_start) && (src_start_alt == src_start)); // R8
endmodule

// File: tb/lcd_tcon_gen_test.sv
module lcd_tcon_gen_test;
  localparam int CLK_PERIOD = 10;
  localparam int CW = 10;
  localparam int NP = 8;
  localparam logic [NP-1:0] LINE_DOM = 8'b1010_0001;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [CW-1:0] h_total, v_total, de_h_start, de_h_len, de_v_start, de_v_len, pol_pos;
  logic [NP-1:0][CW-1:0] p_start, p_width;
  logic [NP-1:0] p_inv;
  logic de_inv, pol_two_line, pol_two_frame, rev_inv, two_phase, sel_gate_alt, sel_src_alt;

  logic gate_start, gate_start_oe, gate_start_alt, gate_start_alt_oe, gate_oe, gate_clk;
  logic src_strobe, src_start, src_start_oe, src_start_alt, src_start_alt_oe, gate_reset;
  logic hsync, vsync, de, line_pol, pix_rev, pix_rev_e, pix_rev_e_oe;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  lcd_tcon_gen #(.CW(CW)) uut (
    .clk, .rst, .h_total, .v_total, .p_start, .p_width, .p_inv,
    .de_h_start, .de_h_len, .de_v_start, .de_v_len, .de_inv,
    .pol_pos, .pol_two_line, .pol_two_frame, .rev_inv, .two_phase,
    .sel_gate_alt, .sel_src_alt,
    .gate_start, .gate_start_oe, .gate_start_alt, .gate_start_alt_oe,
    .gate_oe, .gate_clk, .src_strobe, .src_start, .src_start_oe,
    .src_start_alt, .src_start_alt_oe, .gate_reset, .hsync, .vsync,
    .de, .line_pol, .pix_rev, .pix_rev_e, .pix_rev_e_oe
  );

  // reference model state
  int mh, mv, mf;
  int s_ht, s_vt, s_ps[NP], s_pw[NP], s_dhs, s_dhl, s_dvs, s_dvl, s_ppos;
  bit s_pi[NP], s_dinv, s_p2l, s_p2f, s_rinv, s_two, s_sga, s_ssa;
  bit e_p[NP], e_live_diff[NP], e_de, e_pol, e_rev, e_reve;
  bit in_rst, seen = 0;

  function automatic bit win(int c, int s, int w);
    return (c >= s) && (c < s + w);
  endfunction

  task automatic load_shadow();
    s_ht = int'(h_total); s_vt = int'(v_total);
    for (int i = 0; i < NP; i++) begin
      s_ps[i] = int'(p_start[i]); s_pw[i] = int'(p_width[i]); s_pi[i] = p_inv[i];
    end
    s_dhs = int'(de_h_start); s_dhl = int'(de_h_len);
    s_dvs = int'(de_v_start); s_dvl = int'(de_v_len); s_dinv = de_inv;
    s_ppos = int'(pol_pos); s_p2l = pol_two_line; s_p2f = pol_two_frame;
    s_rinv = rev_inv; s_two = two_phase; s_sga = sel_gate_alt; s_ssa = sel_src_alt;
  endtask

  always @(posedge clk) begin
    if (rst) begin
      mh = 0; mv = 0; mf = 0;
      load_shadow();
      for (int i = 0; i < NP; i++) begin
        e_p[i] = p_inv[i];
        e_live_diff[i] = 0;
      end
      e_de = de_inv; e_pol = 0; e_rev = rev_inv; e_reve = !rev_inv;
      in_rst = 1; seen = 1;
    end else begin
      bit fe;
      in_rst = 0;
      for (int i = 0; i < NP; i++) begin
        int c;
        bit live;
        c = LINE_DOM[i] ? mv : mh;
        e_p[i] = win(c, s_ps[i], s_pw[i]) ^ s_pi[i];
        live = win(c, int'(p_start[i]), int'(p_width[i])) ^ p_inv[i];
        e_live_diff[i] = (live != e_p[i]);
      end
      e_de = (win(mh, s_dhs, s_dhl) && win(mv, s_dvs, s_dvl)) ^ s_dinv;
      if (mh == s_ppos)
        e_pol = (s_p2l ? mv[1] : mv[0]) ^ (s_p2f ? mf[1] : mf[0]);
      e_rev  = s_rinv ^ (!s_two && mh[0]);
      e_reve = !s_rinv;
      fe = (mh == s_ht - 1) && (mv == s_vt - 1);
      if (mh == s_ht - 1) begin
        mh = 0;
        mv = fe ? 0 : mv + 1;
      end else begin
        mh = mh + 1;
      end
      if (fe) begin
        mf = mf + 1;
        load_shadow();
      end
    end
  end

  task automatic chk(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d at t=%0t", req, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (seen && !done) begin
      logic [NP-1:0] act;
      act = {vsync, hsync, gate_reset, src_start, src_strobe, gate_clk, gate_oe, gate_start};
      if (in_rst) begin
        // R1: reset drives the inactive levels
        for (int i = 0; i < NP; i++) chk("R1", $sformatf("pulse%0d", i), int'(act[i]), int'(e_p[i]));
        chk("R1", "de", int'(de), int'(e_de));
        chk("R1", "line_pol", int'(line_pol), 0);
        chk("R1", "pix_rev", int'(pix_rev), int'(e_rev));
        chk("R1", "pix_rev_e", int'(pix_rev_e), int'(e_reve));
      end else begin
        for (int i = 0; i < NP; i++) begin
          string tag;
          if (s_pw[i] == 0)           tag = "R10";
          else if (e_live_diff[i])    tag = "R9";
          else if (i == 6)            tag = "R2";
          else if (LINE_DOM[i])       tag = "R4";
          else                        tag = "R3";
          chk(tag, $sformatf("pulse%0d", i), int'(act[i]), int'(e_p[i]));
        end
        chk("R5", "de", int'(de), int'(e_de));
        chk("R6", "line_pol", int'(line_pol), int'(e_pol));
        chk("R7", "pix_rev", int'(pix_rev), int'(e_rev));
        chk("R7", "pix_rev_e", int'(pix_rev_e), int'(e_reve));
        chk("R7", "pix_rev_e_oe", int'(pix_rev_e_oe), int'(s_two));
      end
      chk("R8", "gate_start_alt", int'(gate_start_alt), int'(gate_start));
      chk("R8", "src_start_alt", int'(src_start_alt), int'(src_start));
      chk("R8", "gate_start_oe", int'({gate_start_oe, gate_start_alt_oe}), s_sga ? 1 : 2);
      chk("R8", "src_start_oe", int'({src_start_oe, src_start_alt_oe}), s_ssa ? 1 : 2);
    end
  end

  task automatic cfg(int k);
    h_total = CW'(12 + (k % 3) * 2);
    v_total = CW'(6 + (k % 2));
    for (int i = 0; i < NP; i++) begin
      p_start[i] = CW'((i * 2 + k) % 10);
      p_width[i] = CW'((i + k) % 5);
      p_inv[i]   = ((i + k) % 3) == 0;
    end
    de_h_start = CW'(1 + k % 3); de_h_len = CW'(7 + k % 4);
    de_v_start = CW'(k % 2);     de_v_len = CW'(3 + k % 3);
    de_inv = k[0];
    pol_pos = CW'((k * 5) % 12);
    pol_two_line = k[0]; pol_two_frame = k[1];
    rev_inv = k[1]; two_phase = k[0];
    sel_gate_alt = k[0]; sel_src_alt = k[1];
  endtask

  initial begin
    cfg(0);
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    repeat (300) @(negedge clk);
    for (int k = 1; k < 6; k++) begin
      repeat (37 + k * 5) @(negedge clk);
      cfg(k);                       // written partway through a frame (R9)
      repeat (260) @(negedge clk);
    end
    repeat (23) @(negedge clk);
    cfg(6);
    rst = 1'b1;                     // mid-run reset (R1)
    repeat (2) @(negedge clk);
    rst = 1'b0;
    repeat (200) @(negedge clk);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule